// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Pinned Entries

This block is a fully associative cache of page translations for the process that currently owns the processor. A lookup presents a virtual page number. The block compares it with every stored entry at once and returns a hit flag and the matching frame number in the same cycle. Each entry also carries an address-space tag, so a stored page only answers when its tag equals the current address-space input. Translations from several processes can therefore stay resident across context switches.

When a lookup misses, an external table walker resolves the page and presents the page/frame pair on the fill port. The fill goes into a free entry when one exists. Otherwise it replaces the least recently used entry among those that are not pinned. A fill can pin its entry, and a pinned entry is never chosen as a victim.

Two invalidation inputs are provided. A plain flush drops every unpinned translation. A full flush drops everything, including the pins.

Top module: `tlb_asid_wired`

## Requirements
- R1: After reset no entry is valid, so every lookup reports `lk_hit`=0. `lk_hit` and `lk_pfn` are combinational in `lk_vpn` and `cur_asid`. `lk_pfn` is the frame of the valid entry whose page and address-space tag both match.
- R2: An entry whose page matches but whose address-space tag differs from `cur_asid` gives a miss. The same page may be resident under two tags with different frames, and each tag sees its own frame.
- R3: A fill accepted at a clock edge makes a lookup of that page, under the same tag, hit with the filled frame from the next cycle on.
- R4: A fill whose page and tag are already resident overwrites that entry's frame in place and takes no new entry. This also applies when the entry is pinned, and the pin flag becomes the OR of the old flag and `fill_wire`.
- R5: A fill of a new page takes the lowest-indexed invalid entry. When no entry is invalid, it takes the unpinned entry least recently used. Use means a fill of the entry, or a lookup of the entry with `lk_req`=1 that hits.
- R6: A pinned entry (filled with `fill_wire`=1) is never replaced by a fill, even when it is the least recently used entry.
- R7: `flush` invalidates every unpinned entry and leaves pinned entries valid and hitting.
- R8: `flush_all` invalidates every entry, pinned or not. A fill presented in the same cycle as `flush` or `flush_all` is discarded.
- R9: A fill of a page that is not resident, while every entry is pinned, is discarded. In that case `ovf` is high for exactly the one cycle after the fill's clock edge, and the stored entries are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_asid | input | ASID_W | Address-space tag of the running process |
| lk_req | input | 1 | Lookup is a real access; a hit refreshes the entry's recency |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | PFN_W | Frame number of the hitting entry, zero on a miss |
| fill_valid | input | 1 | Install a translation this cycle |
| fill_vpn | input | VPN_W | Page number to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_wire | input | 1 | Pin the installed entry against replacement |
| flush | input | 1 | Invalidate all unpinned entries |
| flush_all | input | 1 | Invalidate all entries and clear all pins |
| ovf | output | 1 | A fill was discarded because every entry is pinned |

## Verification
The hardest situation to reach from the ports is a full table in which the least recently used entry is pinned. Only that case shows that victim selection skips pins rather than simply taking the oldest entry. The bench pins one entry first, so it is the oldest, then fills every remaining slot and presents one more fill. It then checks that the pinned page still hits and that the oldest unpinned page is the one that went. Overflow needs every entry pinned, so the bench pins the whole table. It then checks both the dropped fill and an in-place overwrite of a pinned page, which must not raise the flag.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // What an incoming fill does to the entry array.
  typedef enum logic [1:0] {
    FILL_NONE   = 2'd0,
    FILL_UPDATE = 2'd1,
    FILL_ALLOC  = 2'd2,
    FILL_DROP   = 2'd3
  } fill_act_e;
endpackage

// File: rtl/tlb_match.sv
// Parallel compare of one key (page + address-space tag) against all entries.
module tlb_match #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic [N-1:0]      valid,
  input  logic [VPN_W-1:0]  vpn_tab  [N],
  input  logic [ASID_W-1:0] asid_tab [N],
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  output logic [N-1:0]      hit_vec
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (vpn_tab[g] == key_vpn) && (asid_tab[g] == key_asid);
  end
endmodule

// File: rtl/tlb_age.sv
// Recency ranks (0 = most recent) kept as a permutation, plus victim choice.
module tlb_age #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [N-1:0]     cand_mask,
  input  logic [N-1:0]     free_mask,
  output logic [IDX_W-1:0] victim_idx,
  output logic             victim_ok
);
  logic [IDX_W-1:0] age_q [N];
  logic [IDX_W-1:0] age_d [N];
  logic [IDX_W-1:0] ref_age;

  assign ref_age = age_q[touch_idx];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      age_d[i] = age_q[i];
      if (touch_en) begin
        if (touch_idx == IDX_W'(i))  age_d[i] = '0;
        else if (age_q[i] < ref_age) age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) age_q[i] <= age_d[i];
    end
  end

  logic             free_found;
  logic             old_found;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] old_idx;
  logic [IDX_W-1:0] old_age;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    old_found  = 1'b0;
    old_idx    = '0;
    old_age    = '0;
    for (int i = 0; i < N; i++) begin
      if (free_mask[i] && !free_found) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
      if (cand_mask[i] && (!old_found || age_q[i] > old_age)) begin
        old_found = 1'b1;
        old_idx   = IDX_W'(i);
        old_age   = age_q[i];
      end
    end
    victim_idx = free_found ? free_idx : old_idx;
    victim_ok  = free_found || old_found;
  end
endmodule

// File: rtl/tlb_asid_wired.sv
module tlb_asid_wired
  import tlb_pkg::*;
#(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              lk_req,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              fill_wire,
  input  logic              flush,
  input  logic              flush_all,
  output logic              ovf
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]      valid_q, valid_d;
  logic [N-1:0]      wired_q, wired_d;
  logic [VPN_W-1:0]  vpn_q  [N];
  logic [ASID_W-1:0] asid_q [N];
  logic [PFN_W-1:0]  pfn_q  [N];
  logic              ovf_q, ovf_d;

  logic [N-1:0]      lk_vec, fl_vec;
  logic [IDX_W-1:0]  lk_idx, fl_idx, wr_idx, victim_idx, touch_idx;
  logic              victim_ok, touch_en, wr_en;
  fill_act_e         act;

  tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
    .valid(valid_q), .vpn_tab(vpn_q), .asid_tab(asid_q),
    .key_vpn(lk_vpn), .key_asid(cur_asid), .hit_vec(lk_vec));

  tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fl_match (
    .valid(valid_q), .vpn_tab(vpn_q), .asid_tab(asid_q),
    .key_vpn(fill_vpn), .key_asid(cur_asid), .hit_vec(fl_vec));

  // One-hot to index, and OR-mux of the hitting frame.
  always_comb begin
    lk_idx = '0;
    fl_idx = '0;
    lk_pfn = '0;
    for (int i = 0; i < N; i++) begin
      if (lk_vec[i]) begin
        lk_idx = lk_idx | IDX_W'(i);
        lk_pfn = lk_pfn | pfn_q[i];
      end
      if (fl_vec[i]) fl_idx = fl_idx | IDX_W'(i);
    end
  end
  assign lk_hit = |lk_vec;

  // Fill decision.
  always_comb begin
    act = FILL_NONE;
    if (fill_valid && !flush && !flush_all) begin
      if (|fl_vec)        act = FILL_UPDATE;
      else if (victim_ok) act = FILL_ALLOC;
      else                act = FILL_DROP;
    end
    wr_en  = (act == FILL_UPDATE) || (act == FILL_ALLOC);
    wr_idx = (act == FILL_UPDATE) ? fl_idx : victim_idx;
    ovf_d  = (act == FILL_DROP);
  end

  // Recency: a write wins over a concurrent lookup touch.
  always_comb begin
    touch_en  = wr_en || (lk_req && lk_hit);
    touch_idx = wr_en ? wr_idx : lk_idx;
  end

  tlb_age #(.N(N), .IDX_W(IDX_W)) u_age (
    .clk(clk), .rst_n(rst_n),
    .touch_en(touch_en), .touch_idx(touch_idx),
    .cand_mask(~wired_q), .free_mask(~valid_q),
    .victim_idx(victim_idx), .victim_ok(victim_ok));

  // Valid / pin next state.
  always_comb begin
    valid_d = valid_q;
    wired_d = wired_q;
    if (flush_all) begin
      valid_d = '0;
      wired_d = '0;
    end else if (flush) begin
      valid_d = valid_q & wired_q;
    end else if (wr_en) begin
      valid_d[wr_idx] = 1'b1;
      wired_d[wr_idx] = (act == FILL_UPDATE) ? (wired_q[wr_idx] | fill_wire) : fill_wire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      wired_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      wired_q <= wired_d;
      ovf_q   <= ovf_d;
    end
  end

  // Payload storage: no reset, written only under its enable.
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (wr_en && (wr_idx == IDX_W'(i))) begin
        vpn_q[i]  <= fill_vpn;
        asid_q[i] <= cur_asid;
        pfn_q[i]  <= fill_pfn;
      end
    end
  end

  assign ovf = ovf_q;
endmodule

// File: rtl/tlb_asid_wired_chk.sv
module tlb_asid_wired_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         fill_valid,
  input logic         flush,
  input logic         flush_all,
  input logic         ovf,
  input logic [N-1:0] valid_q,
  input logic [N-1:0] wired_q,
  input logic [N-1:0] lk_vec,
  input logic [N-1:0] fl_vec
);
  // R4: in-place overwrite keeps at most one entry per page and tag.
  assert_single_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_vec));
  assert_single_fill_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fl_vec));

  // R7: a plain flush leaves only pinned entries.
  assert_flush_keeps_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !flush_all) |=> ((valid_q & ~wired_q) == '0));

  // R8: a full flush empties the table.
  assert_flush_all_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_q == '0 && wired_q == '0));

  // R9: the overflow flag only follows an accepted fill request.
  assert_ovf_after_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> $past(fill_valid && !flush && !flush_all));

  // R6: a pinned entry survives every cycle without a full flush.
  for (genvar g = 0; g < N; g++) begin : g_pin
    assert_pin_survives_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wired_q[g] && !flush_all) |=> (valid_q[g] && wired_q[g]));
  end
endmodule

bind tlb_asid_wired tlb_asid_wired_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .flush(flush),
  .flush_all(flush_all), .ovf(ovf_q), .valid_q(valid_q), .wired_q(wired_q),
  .lk_vec(lk_vec), .fl_vec(fl_vec));

// File: tb/test_tlb_asid_wired.sv
module test_tlb_asid_wired;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16, VPN_W = 20, PFN_W = 20, ASID_W = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ASID_W-1:0] cur_asid;
  logic              lk_req;
  logic [VPN_W-1:0]  lk_vpn;
  logic              lk_hit;
  logic [PFN_W-1:0]  lk_pfn;
  logic              fill_valid, fill_wire, flush, flush_all, ovf;
  logic [VPN_W-1:0]  fill_vpn;
  logic [PFN_W-1:0]  fill_pfn;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_asid_wired #(.N(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) i_tlb_asid_wired (
    .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid), .lk_req(lk_req), .lk_vpn(lk_vpn),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_wire(fill_wire), .flush(flush), .flush_all(flush_all),
    .ovf(ovf));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Probe without touching recency.
  task automatic probe(input int vpn, input bit exp_hit, input int exp_pfn, input string req);
    @(negedge clk);
    lk_vpn = VPN_W'(vpn);
    lk_req = 1'b0;
    #1;
    check(lk_hit == exp_hit, req, int'(lk_hit), int'(exp_hit));
    if (exp_hit) check(lk_pfn == PFN_W'(exp_pfn), req, int'(lk_pfn), exp_pfn);
  endtask

  task automatic touch(input int vpn);
    @(negedge clk);
    lk_vpn = VPN_W'(vpn);
    lk_req = 1'b1;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic fill(input int vpn, input int pfn, input bit wire_it);
    @(negedge clk);
    fill_valid = 1'b1;
    fill_vpn   = VPN_W'(vpn);
    fill_pfn   = PFN_W'(pfn);
    fill_wire  = wire_it;
    @(negedge clk);
    fill_valid = 1'b0;
    fill_wire  = 1'b0;
  endtask

  task automatic pulse_flush(input bit all);
    @(negedge clk);
    if (all) flush_all = 1'b1; else flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    flush_all = 1'b0;
  endtask

  task automatic t_reset;
    probe(0, 1'b0, 0, "R1 reset miss");
    probe(123, 1'b0, 0, "R1 reset miss");
    check(ovf == 1'b0, "R9 ovf low after reset", int'(ovf), 0);
  endtask

  task automatic t_basic_and_asid;
    cur_asid = 8'd1;
    fill(55, 1000, 1'b0);
    probe(55, 1'b1, 1000, "R3 hit after fill");
    probe(56, 1'b0, 0, "R1 other page misses");
    cur_asid = 8'd2;
    probe(55, 1'b0, 0, "R2 tag mismatch misses");
    fill(55, 2000, 1'b0);
    probe(55, 1'b1, 2000, "R2 second tag own frame");
    cur_asid = 8'd1;
    probe(55, 1'b1, 1000, "R2 first tag own frame");
    fill(55, 1500, 1'b0);
    probe(55, 1'b1, 1500, "R4 overwrite in place");
  endtask

  task automatic t_lru;
    pulse_flush(1'b1);
    probe(55, 1'b0, 0, "R8 flush_all clears");
    cur_asid = 8'd1;
    for (int i = 0; i < N; i++) fill(i, 500 + i, 1'b0);
    touch(0);
    fill(16, 516, 1'b0);
    probe(1, 1'b0, 0, "R5 LRU entry replaced");
    probe(0, 1'b1, 500, "R5 touched entry kept");
    probe(16, 1'b1, 516, "R5 new entry present");
    probe(2, 1'b1, 502, "R5 others kept");
    // Overwrite of a resident page must not evict anything.
    fill(5, 905, 1'b0);
    for (int i = 0; i < N; i++)
      if (i != 1) probe(i == 0 ? 0 : i, 1'b1, i == 5 ? 905 : 500 + i, "R4 no allocation on overwrite");
    probe(16, 1'b1, 516, "R4 no allocation on overwrite");
  endtask

  task automatic t_wired_and_flush;
    pulse_flush(1'b1);
    fill(100, 7100, 1'b1);
    for (int i = 0; i < N - 1; i++) fill(200 + i, 7200 + i, 1'b0);
    fill(215, 7215, 1'b0);
    probe(100, 1'b1, 7100, "R6 pinned oldest kept");
    probe(200, 1'b0, 0, "R6 oldest unpinned replaced");
    probe(215, 1'b1, 7215, "R6 new entry present");
    pulse_flush(1'b0);
    probe(100, 1'b1, 7100, "R7 pinned survives flush");
    probe(201, 1'b0, 0, "R7 unpinned flushed");
    // Fill concurrent with flush is discarded.
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = 20'd77; fill_pfn = 20'd77; flush = 1'b1;
    @(negedge clk);
    fill_valid = 1'b0; flush = 1'b0;
    probe(77, 1'b0, 0, "R8 fill dropped during flush");
    pulse_flush(1'b1);
    probe(100, 1'b0, 0, "R8 flush_all clears pinned");
  endtask

  task automatic t_overflow;
    for (int i = 0; i < N; i++) fill(300 + i, 8300 + i, 1'b1);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = 20'd400; fill_pfn = 20'd8400; fill_wire = 1'b0;
    @(negedge clk);
    check(ovf == 1'b1, "R9 ovf raised", int'(ovf), 1);
    fill_valid = 1'b0;
    @(negedge clk);
    check(ovf == 1'b0, "R9 ovf one cycle", int'(ovf), 0);
    probe(400, 1'b0, 0, "R9 dropped fill absent");
    probe(300, 1'b1, 8300, "R9 entries unchanged");
    probe(315, 1'b1, 8315, "R9 entries unchanged");
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = 20'd305; fill_pfn = 20'd9305;
    @(negedge clk);
    check(ovf == 1'b0, "R4 overwrite of pinned no ovf", int'(ovf), 0);
    fill_valid = 1'b0;
    probe(305, 1'b1, 9305, "R4 pinned overwritten in place");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cur_asid = '0; lk_req = 1'b0; lk_vpn = '0;
    fill_valid = 1'b0; fill_vpn = '0; fill_pfn = '0; fill_wire = 1'b0;
    flush = 1'b0; flush_all = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic_and_asid();
    t_lru();
    t_wired_and_flush();
    t_overflow();
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule